// File: doc/BRIEF.md
# Linked-Descriptor Card DMA Walker

This block is the bus-master part of a memory-card host. A start pulse, given while the software setup is valid, makes it walk a list of descriptors held in system memory. Each descriptor is four words: a control/status word, a buffer length, a buffer pointer and a link to the following descriptor. For every descriptor it moves whole 32-bit words between the buffer and the card data stream. It then hands the descriptor back to software by rewriting the status word with the ownership flag cleared, and follows the link. It stops when the programmed byte count is used up or a descriptor flagged as final has been served.

The transfer direction is latched from the command's write flag. Write moves data from memory to the card; read moves it from the card to memory. Memory is reached through a single-word request/acknowledge port with one access in flight. The card side is a pair of valid/ready word streams. When the walk ends, a one-cycle group of event pulses reports the result. The host's interrupt logic collects these pulses.

Top module: `chain_dma`

## Requirements
- R1: Descriptor words sit at the descriptor address plus 0 (status), 4 (length), 8 (buffer pointer) and 12 (link). The walk begins at `desc_base_i` and moves to the link address when it continues. Address bits [1:0] are ignored.
- R2: A start pulse has no effect while `dma_en_i` is low, `byte_count_i` is zero or `block_size_i` is zero. No memory request is made and `busy_o` stays low.
- R3: With `wr_dir_i`=1, buffer words go to the card on `card_tx_*`. With `wr_dir_i`=0, card words from `card_rx_*` are written into the buffer, and no memory access is made until `card_rdy_i` is high.
- R4: Each descriptor moves min(length rounded up to a multiple of 4, remaining count) bytes, as whole words. The buffer pointer's bits [1:0] are treated as zero.
- R5: A length of 0 means MAX_BYTES. A length above MAX_BYTES is cut to MAX_BYTES.
- R6: After a descriptor's data has moved, its status word is written back to offset 0 with bit 31 (ownership) cleared and every other bit unchanged.
- R7: The walk ends after a descriptor whose status bit 2 (final) is set, or once the remaining count is zero. In the second case the link is not fetched.
- R8: A successful end pulses `done_o`, `evt_data_o`, `evt_sdio_o` and `evt_sum_o` for one cycle, together with `evt_tx_o` for a write or `evt_rx_o` for a read.
- R9: `remain_o` loads the byte count at start and drops by each descriptor's moved bytes. `cnt_zero_o` pulses once in the cycle after it reaches zero.
- R10: A fetched status word with bit 31 clear stops the walk. No data moves, no write-back is made and `remain_o` is unchanged. `done_o`, `evt_err_o` and `evt_sum_o` pulse, with no data, tx or rx event.
- R11: `busy_o` is high from an accepted start until the cycle `done_o` pulses. All memory requests and card handshakes fall inside that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command issued with data phase |
| dma_en_i | input | 1 | DMA enable from global control |
| wr_dir_i | input | 1 | 1 = memory to card, 0 = card to memory |
| byte_count_i | input | 32 | Total bytes for the transfer |
| block_size_i | input | 32 | Card block size (must be nonzero) |
| desc_base_i | input | 32 | Address of the first descriptor |
| card_rdy_i | input | 1 | Card has read data available |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write access |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access complete; read data valid |
| mem_rdata_i | input | 32 | Read data |
| card_tx_valid_o | output | 1 | Word to card valid |
| card_tx_data_o | output | 32 | Word to card |
| card_tx_ready_i | input | 1 | Card accepts word |
| card_rx_valid_i | input | 1 | Word from card valid |
| card_rx_data_i | input | 32 | Word from card |
| card_rx_ready_o | output | 1 | Block accepts card word |
| busy_o | output | 1 | Walk in progress |
| remain_o | output | 32 | Remaining byte count |
| cnt_zero_o | output | 1 | Remaining count just reached zero |
| done_o | output | 1 | Walk finished (pulse) |
| evt_data_o | output | 1 | Data complete (pulse) |
| evt_sdio_o | output | 1 | Card-interrupt event on completion (pulse) |
| evt_sum_o | output | 1 | DMA summary (pulse) |
| evt_tx_o | output | 1 | Transmit complete (pulse) |
| evt_rx_o | output | 1 | Receive complete (pulse) |
| evt_err_o | output | 1 | Descriptor not owned (pulse) |

## Verification
The bench targets the end conditions. The first is a count that runs out inside a descriptor that has no final flag; a design that always followed the link would fetch, and wrongly release, the next descriptor. The second is a final flag hit while bytes still remain; a design that kept walking would overrun the list. The length corner cases are a zero length, an oversized length, a 6-byte length and a pointer with its low bits set. Getting the clamp or the rounding wrong changes the number of words seen at the card. An unowned descriptor must leave memory and the count untouched. A read started before the card is ready must make no memory request.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned HOLD_BIT = 31;
  localparam int unsigned LAST_BIT = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT_CARD, ST_FETCH, ST_MEM_RD, ST_CARD_TX,
    ST_CARD_RX, ST_MEM_WR, ST_WBACK, ST_DONE, ST_FAIL
  } walk_st_e;
endpackage

// File: rtl/chain_dma_sizer.sv
module chain_dma_sizer
  import chain_dma_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 8192
) (
  input  logic [DW-1:0] size_i,
  input  logic [DW-1:0] remain_i,
  output logic [DW-1:0] chunk_o,
  output logic [DW-1:0] words_o
);
  localparam logic [DW-1:0] MAX_V = DW'(MAX_BYTES);

  logic [DW-1:0] eff, rnd;

  always_comb begin
    eff     = (size_i == '0 || size_i > MAX_V) ? MAX_V : size_i;
    rnd     = (eff + DW'(3)) & ~DW'(3);
    chunk_o = (rnd < remain_i) ? rnd : remain_i;
    words_o = {2'b00, chunk_o[DW-1:2]} + DW'(chunk_o[1:0] != 2'b00);
  end
endmodule

// File: rtl/chain_dma_ctrl.sv
module chain_dma_ctrl
  import chain_dma_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 8192
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          dma_en_i,
  input  logic          wr_dir_i,
  input  logic [DW-1:0] byte_count_i,
  input  logic [DW-1:0] block_size_i,
  input  logic [DW-1:0] desc_base_i,
  input  logic          card_rdy_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          card_tx_valid_o,
  output logic [DW-1:0] card_tx_data_o,
  input  logic          card_tx_ready_i,
  input  logic          card_rx_valid_i,
  input  logic [DW-1:0] card_rx_data_i,
  output logic          card_rx_ready_o,
  output logic          busy_o,
  output logic [DW-1:0] remain_o,
  output logic          cnt_zero_o,
  output logic          fin_o,
  output logic          fin_err_o,
  output logic          fin_wr_o
);
  localparam int unsigned WA = DW - 2;

  walk_st_e      st;
  logic [WA-1:0] dptr, d_buf, d_next, bptr;
  logic [1:0]    idx;
  logic [DW-1:0] d_status, d_size, remain, chunk_q, words_left, data_q;
  logic [DW-1:0] chunk, words;
  logic          wr_q, zero_q, accept, word_step;

  chain_dma_sizer #(.MAX_BYTES(MAX_BYTES)) u_sizer (
    .size_i  (d_size),
    .remain_i(remain),
    .chunk_o (chunk),
    .words_o (words)
  );

  assign accept    = (st == ST_IDLE) && start_i && dma_en_i &&
                     (byte_count_i != '0) && (block_size_i != '0);
  assign word_step = ((st == ST_CARD_TX) && card_tx_ready_i) ||
                     ((st == ST_MEM_WR) && mem_ack_i);

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (st)
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {dptr + WA'(idx), 2'b00};
      end
      ST_MEM_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {bptr, 2'b00};
      end
      ST_MEM_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {bptr, 2'b00};
        mem_wdata_o = data_q;
      end
      ST_WBACK: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {dptr, 2'b00};
        mem_wdata_o = d_status & ~(DW'(1) << HOLD_BIT);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= ST_IDLE;
      dptr       <= '0;
      d_buf      <= '0;
      d_next     <= '0;
      bptr       <= '0;
      idx        <= '0;
      d_status   <= '0;
      d_size     <= '0;
      remain     <= '0;
      chunk_q    <= '0;
      words_left <= '0;
      data_q     <= '0;
      wr_q       <= 1'b0;
      zero_q     <= 1'b0;
    end else begin
      zero_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          wr_q   <= wr_dir_i;
          remain <= byte_count_i;
          dptr   <= desc_base_i[DW-1:2];
          idx    <= '0;
          st     <= wr_dir_i ? ST_FETCH : ST_WAIT_CARD;
        end
        ST_WAIT_CARD: if (card_rdy_i) st <= ST_FETCH;
        ST_FETCH: if (mem_ack_i) begin
          idx <= idx + 2'd1;
          unique case (idx)
            2'd0: begin
              d_status <= mem_rdata_i;
              if (!mem_rdata_i[HOLD_BIT]) st <= ST_FAIL;
            end
            2'd1: d_size <= mem_rdata_i;
            2'd2: d_buf  <= mem_rdata_i[DW-1:2];
            default: begin
              d_next     <= mem_rdata_i[DW-1:2];
              chunk_q    <= chunk;
              words_left <= words;
              bptr       <= d_buf;
              st         <= wr_q ? ST_MEM_RD : ST_CARD_RX;
            end
          endcase
        end
        ST_MEM_RD: if (mem_ack_i) begin
          data_q <= mem_rdata_i;
          st     <= ST_CARD_TX;
        end
        ST_CARD_RX: if (card_rx_valid_i) begin
          data_q <= card_rx_data_i;
          st     <= ST_MEM_WR;
        end
        ST_WBACK: if (mem_ack_i) begin
          if (remain == '0 || d_status[LAST_BIT]) begin
            st <= ST_DONE;
          end else begin
            dptr <= d_next;
            idx  <= '0;
            st   <= ST_FETCH;
          end
        end
        ST_DONE, ST_FAIL: st <= ST_IDLE;
        default: ;
      endcase
      if (word_step) begin
        bptr       <= bptr + WA'(1);
        words_left <= words_left - DW'(1);
        if (words_left == DW'(1)) begin
          remain <= remain - chunk_q;
          zero_q <= (remain == chunk_q);
          st     <= ST_WBACK;
        end else begin
          st <= wr_q ? ST_MEM_RD : ST_CARD_RX;
        end
      end
    end
  end

  assign card_tx_valid_o = (st == ST_CARD_TX);
  assign card_tx_data_o  = data_q;
  assign card_rx_ready_o = (st == ST_CARD_RX);
  assign busy_o          = (st != ST_IDLE);
  assign remain_o        = remain;
  assign cnt_zero_o      = zero_q;
  assign fin_o           = (st == ST_DONE) || (st == ST_FAIL);
  assign fin_err_o       = (st == ST_FAIL);
  assign fin_wr_o        = wr_q;
endmodule

// File: rtl/chain_dma_events.sv
module chain_dma_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fin_i,
  input  logic err_i,
  input  logic wr_i,
  output logic done_o,
  output logic evt_data_o,
  output logic evt_sdio_o,
  output logic evt_sum_o,
  output logic evt_tx_o,
  output logic evt_rx_o,
  output logic evt_err_o
);
  logic ok;
  assign ok = fin_i && !err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      evt_data_o <= 1'b0;
      evt_sdio_o <= 1'b0;
      evt_sum_o  <= 1'b0;
      evt_tx_o   <= 1'b0;
      evt_rx_o   <= 1'b0;
      evt_err_o  <= 1'b0;
    end else begin
      done_o     <= fin_i;
      evt_data_o <= ok;
      evt_sdio_o <= ok;
      evt_sum_o  <= fin_i;
      evt_tx_o   <= ok && wr_i;
      evt_rx_o   <= ok && !wr_i;
      evt_err_o  <= fin_i && err_i;
    end
  end
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 8192
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          dma_en_i,
  input  logic          wr_dir_i,
  input  logic [DW-1:0] byte_count_i,
  input  logic [DW-1:0] block_size_i,
  input  logic [DW-1:0] desc_base_i,
  input  logic          card_rdy_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          card_tx_valid_o,
  output logic [DW-1:0] card_tx_data_o,
  input  logic          card_tx_ready_i,
  input  logic          card_rx_valid_i,
  input  logic [DW-1:0] card_rx_data_i,
  output logic          card_rx_ready_o,
  output logic          busy_o,
  output logic [DW-1:0] remain_o,
  output logic          cnt_zero_o,
  output logic          done_o,
  output logic          evt_data_o,
  output logic          evt_sdio_o,
  output logic          evt_sum_o,
  output logic          evt_tx_o,
  output logic          evt_rx_o,
  output logic          evt_err_o
);
  logic fin, fin_err, fin_wr;

  chain_dma_ctrl #(.MAX_BYTES(MAX_BYTES)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .dma_en_i, .wr_dir_i,
    .byte_count_i, .block_size_i, .desc_base_i, .card_rdy_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .card_tx_valid_o, .card_tx_data_o, .card_tx_ready_i,
    .card_rx_valid_i, .card_rx_data_i, .card_rx_ready_o,
    .busy_o, .remain_o, .cnt_zero_o,
    .fin_o(fin), .fin_err_o(fin_err), .fin_wr_o(fin_wr)
  );

  chain_dma_events u_evt (
    .clk_i, .rst_ni,
    .fin_i(fin), .err_i(fin_err), .wr_i(fin_wr),
    .done_o, .evt_data_o, .evt_sdio_o, .evt_sum_o,
    .evt_tx_o, .evt_rx_o, .evt_err_o
  );
endmodule

// File: rtl/chain_dma_chk.sv
module chain_dma_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_ack_i,
  input logic        card_tx_valid_o,
  input logic        card_rx_ready_o,
  input logic        busy_o,
  input logic [31:0] remain_o,
  input logic        done_o,
  input logic        evt_data_o,
  input logic        evt_sdio_o,
  input logic        evt_sum_o,
  input logic        evt_tx_o,
  input logic        evt_rx_o,
  input logic        evt_err_o
);
  assert_traffic_in_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || card_tx_valid_o || card_rx_ready_o) |-> busy_o);

  assert_req_held_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_word_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  assert_remain_monotonic_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (remain_o <= $past(remain_o)));

  assert_ok_events_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_data_o |-> (done_o && evt_sdio_o && evt_sum_o && (evt_tx_o != evt_rx_o)));

  assert_dir_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({evt_tx_o, evt_rx_o, evt_err_o}));

  assert_err_alone_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_err_o |-> (done_o && evt_sum_o && !evt_data_o && !evt_sdio_o));

  assert_card_dir_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(card_tx_valid_o && card_rx_ready_o));
endmodule

bind chain_dma chain_dma_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
  .card_tx_valid_o(card_tx_valid_o), .card_rx_ready_o(card_rx_ready_o),
  .busy_o(busy_o), .remain_o(remain_o), .done_o(done_o),
  .evt_data_o(evt_data_o), .evt_sdio_o(evt_sdio_o), .evt_sum_o(evt_sum_o),
  .evt_tx_o(evt_tx_o), .evt_rx_o(evt_rx_o), .evt_err_o(evt_err_o)
);

// File: tb/sim_chain_dma.sv
module sim_chain_dma;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 0, dma_en = 0, wr_dir = 0, card_rdy = 0;
  logic [31:0] byte_count = 0, block_size = 0, desc_base = 0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, rx_valid, rx_ready;
  logic [31:0] tx_data, rx_data;
  logic        busy, cnt_zero, done, e_data, e_sdio, e_sum, e_tx, e_rx, e_err;
  logic [31:0] remain;

  logic [31:0] mem [0:255];
  logic [31:0] tx_log [0:63];
  int          tx_n = 0, rx_n = 0;
  logic        tog = 1'b0, zero_seen = 1'b0, req_seen = 1'b0, busy_seen = 1'b0;
  logic        c_data, c_sdio, c_sum, c_tx, c_rx, c_err;
  int          n_chk = 0, n_fail = 0;

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[9:2]];
  assign tx_ready  = tog;
  assign rx_valid  = ~tog;
  assign rx_data   = 32'hC0DE_0000 + rx_n;

  chain_dma #(.MAX_BYTES(64)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dma_en_i(dma_en), .wr_dir_i(wr_dir),
    .byte_count_i(byte_count), .block_size_i(block_size), .desc_base_i(desc_base),
    .card_rdy_i(card_rdy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .card_tx_valid_o(tx_valid), .card_tx_data_o(tx_data), .card_tx_ready_i(tx_ready),
    .card_rx_valid_i(rx_valid), .card_rx_data_i(rx_data), .card_rx_ready_o(rx_ready),
    .busy_o(busy), .remain_o(remain), .cnt_zero_o(cnt_zero), .done_o(done),
    .evt_data_o(e_data), .evt_sdio_o(e_sdio), .evt_sum_o(e_sum),
    .evt_tx_o(e_tx), .evt_rx_o(e_rx), .evt_err_o(e_err)
  );

  always @(posedge clk) begin
    tog <= ~tog;
    if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (tx_valid && tx_ready) begin
      if (tx_n < 64) tx_log[tx_n] <= tx_data;
      tx_n <= tx_n + 1;
    end
    if (rx_valid && rx_ready) rx_n <= rx_n + 1;
    if (cnt_zero) zero_seen <= 1'b1;
    if (mem_req) req_seen <= 1'b1;
    if (busy) busy_seen <= 1'b1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic put_desc(input int a, input logic [31:0] st, input logic [31:0] sz,
                          input logic [31:0] bufp, input logic [31:0] nxt);
    mem[a/4] = st; mem[a/4+1] = sz; mem[a/4+2] = bufp; mem[a/4+3] = nxt;
  endtask

  task automatic fill_src();
    for (int i = 64; i < 128; i++) mem[i] = 32'hA000_0000 + i;
  endtask

  task automatic clear_mon();
    @(negedge clk);
    tx_n = 0; rx_n = 0; zero_seen = 0; req_seen = 0; busy_seen = 0;
  endtask

  task automatic pulse_start(input bit wr, input logic [31:0] bc, input logic [31:0] base);
    @(negedge clk);
    wr_dir = wr; byte_count = bc; desc_base = base; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (done !== 1'b1 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (done !== 1'b1) check(0, "R11 watchdog waiting for done_o", 0, 1);
    c_data = e_data; c_sdio = e_sdio; c_sum = e_sum;
    c_tx = e_tx; c_rx = e_rx; c_err = e_err;
    check(busy === 1'b0, "R11 busy_o low with done_o", {31'b0, busy}, 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk_eq("R11 reset busy_o", {31'b0, busy}, 0);
    chk_eq("R11 reset mem_req_o", {31'b0, mem_req}, 0);
    chk_eq("R8 reset done_o", {31'b0, done}, 0);
    chk_eq("R9 reset remain_o", remain, 0);
  endtask

  task automatic t_gating();
    put_desc(32'hE0, 32'h8000_0004, 16, 32'h100, 0);
    block_size = 512; dma_en = 0;
    clear_mon(); pulse_start(1, 16, 32'hE0); repeat (10) @(negedge clk);
    chk_eq("R2 disabled: no request", {31'b0, req_seen | busy_seen}, 0);
    dma_en = 1;
    clear_mon(); pulse_start(1, 0, 32'hE0); repeat (10) @(negedge clk);
    chk_eq("R2 zero count: no request", {31'b0, req_seen | busy_seen}, 0);
    block_size = 0;
    clear_mon(); pulse_start(1, 16, 32'hE0); repeat (10) @(negedge clk);
    chk_eq("R2 zero block size: no request", {31'b0, req_seen | busy_seen}, 0);
    block_size = 512;
  endtask

  task automatic t_write_single();
    fill_src();
    put_desc(32'h40, 32'h8000_000C, 16, 32'h100, 0);
    clear_mon(); pulse_start(1, 16, 32'h40); wait_done();
    chk_eq("R3 write word count", tx_n, 4);
    for (int i = 0; i < 4; i++) chk_eq("R3 write data", tx_log[i], 32'hA000_0040 + i);
    chk_eq("R6 status written back", mem[32'h40/4], 32'h0000_000C);
    chk_eq("R8 write events", {26'b0, c_data, c_sdio, c_sum, c_tx, c_rx, c_err}, 32'b111100);
    chk_eq("R9 remain after write", remain, 0);
    chk_eq("R9 zero pulse seen", {31'b0, zero_seen}, 1);
  endtask

  task automatic t_read_chain();
    put_desc(32'h00, 32'h8000_0010, 8, 32'h200, 32'h20);
    put_desc(32'h20, 32'h8000_0004, 8, 32'h240, 0);
    card_rdy = 1;
    clear_mon(); pulse_start(0, 16, 32'h00); wait_done();
    chk_eq("R1 read desc A word 0", mem[32'h200/4], 32'hC0DE_0000);
    chk_eq("R1 read desc A word 1", mem[32'h204/4], 32'hC0DE_0001);
    chk_eq("R1 link followed word 0", mem[32'h240/4], 32'hC0DE_0002);
    chk_eq("R1 link followed word 1", mem[32'h244/4], 32'hC0DE_0003);
    chk_eq("R6 status A released", mem[0], 32'h0000_0010);
    chk_eq("R6 status B released", mem[32'h20/4], 32'h0000_0004);
    chk_eq("R8 read events", {26'b0, c_data, c_sdio, c_sum, c_tx, c_rx, c_err}, 32'b111010);
  endtask

  task automatic t_count_ends();
    fill_src();
    put_desc(32'h60, 32'h8000_0000, 32, 32'h100, 32'h70);
    put_desc(32'h70, 32'h8000_0004, 16, 32'h100, 0);
    clear_mon(); pulse_start(1, 8, 32'h60); wait_done();
    chk_eq("R7 count end word count", tx_n, 2);
    chk_eq("R7 link not fetched or released", mem[32'h70/4], 32'h8000_0004);
    chk_eq("R9 remain after count end", remain, 0);
  endtask

  task automatic t_clamp();
    fill_src();
    put_desc(32'h80, 32'h8000_0000, 0, 32'h100, 32'h90);
    put_desc(32'h90, 32'h8000_0004, 200, 32'h180, 0);
    clear_mon(); pulse_start(1, 100, 32'h80); wait_done();
    chk_eq("R5 zero+oversize total words", tx_n, 25);
    chk_eq("R5 zero length ends at max", tx_log[15], 32'hA000_004F);
    chk_eq("R5 second buffer start", tx_log[16], 32'hA000_0060);
    chk_eq("R5 last word of clamped", tx_log[24], 32'hA000_0068);
  endtask

  task automatic t_round_align();
    fill_src();
    put_desc(32'hA0, 32'h8000_0004, 6, 32'h103, 0);
    clear_mon(); pulse_start(1, 6, 32'hA0); wait_done();
    chk_eq("R4 6-byte length moves 2 words", tx_n, 2);
    chk_eq("R4 pointer low bits dropped", tx_log[0], 32'hA000_0040);
    chk_eq("R4 remain after rounding", remain, 0);
  endtask

  task automatic t_last_early();
    fill_src();
    put_desc(32'hB0, 32'h8000_0004, 8, 32'h100, 32'hE0);
    clear_mon(); pulse_start(1, 32, 32'hB0); wait_done();
    chk_eq("R7 final flag stops walk", tx_n, 2);
    chk_eq("R9 remain left over", remain, 24);
    chk_eq("R9 no zero pulse", {31'b0, zero_seen}, 0);
    chk_eq("R8 data event on final flag", {31'b0, c_data}, 1);
  endtask

  task automatic t_not_owned();
    put_desc(32'hC0, 32'h0000_0004, 16, 32'h100, 0);
    clear_mon(); pulse_start(1, 16, 32'hC0); wait_done();
    chk_eq("R10 error events", {26'b0, c_data, c_sdio, c_sum, c_tx, c_rx, c_err}, 32'b001001);
    chk_eq("R10 no data moved", tx_n, 0);
    chk_eq("R10 status untouched", mem[32'hC0/4], 32'h0000_0004);
    chk_eq("R10 remain unchanged", remain, 16);
  endtask

  task automatic t_read_wait();
    put_desc(32'hD0, 32'h8000_0004, 4, 32'h2C0, 0);
    mem[32'h2C0/4] = 0;
    card_rdy = 0;
    clear_mon(); pulse_start(0, 4, 32'hD0); repeat (12) @(negedge clk);
    chk_eq("R3 no request before card ready", {31'b0, req_seen}, 0);
    chk_eq("R11 busy while waiting", {31'b0, busy}, 1);
    card_rdy = 1;
    wait_done();
    chk_eq("R3 read word stored", mem[32'h2C0/4], 32'hC0DE_0000);
    chk_eq("R8 rx event after wait", {31'b0, c_rx}, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_gating();
    t_write_single();
    t_read_chain();
    t_count_ends();
    t_clamp();
    t_round_align();
    t_last_early();
    t_not_owned();
    t_read_wait();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R11 global watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule